// File: doc/BRIEF.md
# Dual-Mode Integer Haar Lifting Unit

This block is a one-dimensional, integer-to-integer Haar wavelet datapath built on the lifting scheme. Each clock cycle it takes one pair of signed operands and a mode bit, and it produces one pair of results a cycle later.

In forward mode the pair is an even and an odd sample. The block returns their difference (the detail) and the floored mean (the smooth). In inverse mode the pair is a smooth and a detail coefficient. The block returns the even and the odd samples that produced them. The transform is lossless, so an inverse pass rebuilds the original samples bit for bit.

Both modes share a single subtractor and a single adder. Small operand multiplexers in front of them pick the mode. Halving with floor rounding is an arithmetic one-bit shift, which is only wiring. Splitting a serial stream into pairs, multi-level decomposition and coefficient storage are left to the surrounding logic.

Top module: `haar_lift_unit`

## Requirements
- R1: With mode = 0 (forward), `in_a` is the even sample and `in_b` the odd sample. `y1` becomes the detail odd − even, exact in W+1 bits.
- R2: In forward mode `y2` becomes floor((even + odd)/2) in W bits. For example, even 0 with odd +13 gives 6, and even 0 with odd −13 gives −7.
- R3: With mode = 1 (inverse), `in_a` is the smooth s and `in_b` the detail d. `y1` becomes the even sample s − floor(d/2).
- R4: In inverse mode `y2` becomes the odd sample d + even.
- R5: Feeding the forward results of any pair of W-bit samples back in inverse mode returns the original samples exactly. This includes the extreme values −2^(W−1) and 2^(W−1)−1.
- R6: Results and `out_valid` appear exactly one clock after an enabled input pair. Back-to-back pairs are accepted on every cycle.
- R7: While `en` is low, `y1` and `y2` hold their values and `out_valid` is low on the following cycle.
- R8: The mode is taken per pair. Alternating the mode on consecutive cycles gives each pair the result of its own mode.
- R9: A synchronous active-high `rst` clears `y1`, `y2` and `out_valid` at the next clock edge.
- R10: A stream of N samples (N/2 pairs on consecutive cycles) is fully processed within N/2+1 clock cycles. For example, 16 samples finish in 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept the pair presented this cycle |
| mode | input | 1 | 0 = forward, 1 = inverse |
| in_a | input | W | Even sample (forward) or smooth coefficient (inverse), signed |
| in_b | input | W+1 | Odd sample sign-extended (forward) or detail coefficient (inverse), signed |
| y1 | output | W+1 | Detail (forward) or rebuilt even sample sign-extended (inverse) |
| y2 | output | W | Smooth (forward) or rebuilt odd sample (inverse) |
| out_valid | output | 1 | High one cycle after an accepted pair |

## Verification
The assertions assume two things about the inputs:
- In forward mode, `in_b` holds a value that fits in W signed bits.
- In inverse mode, the smooth and detail pair is one that some forward pass of W-bit samples could have produced.

Without these, the rebuilt samples could fall outside W bits. The stimulus respects both conditions:
- It drives every forward pair from W-bit samples.
- It feeds the inverse mode only with coefficients captured from the block's own forward outputs, over all pairs of a small word width.

// File: rtl/haar_lift_pkg.sv
package haar_lift_pkg;
  typedef enum logic {
    LIFT_FWD = 1'b0,
    LIFT_INV = 1'b1
  } lift_mode_e;
endpackage

// File: rtl/haar_half.sv
// Floor of x/2: a one-bit move toward the LSB with the sign bit copied into the MSB.
module haar_half #(
  parameter int N = 18
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] y
);
  assign y = {x[N-1], x[N-1:1]};
endmodule

// File: rtl/haar_lift_core.sv
// Shared lifting datapath: one subtractor, one adder, operand muxes, two halvers.
module haar_lift_core
  import haar_lift_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         mode,
  input  logic [W-1:0] in_a,
  input  logic [W:0]   in_b,
  output logic [W:0]   res1,
  output logic [W-1:0] res2
);
  localparam int IW = W + 2;

  logic [IW-1:0] a_ext, b_ext, b_half;
  logic [IW-1:0] sub_m, sub_s, diff, diff_half;
  logic [IW-1:0] add_x, add_y, sum;
  logic          inv;

  assign inv   = (lift_mode_e'(mode) == LIFT_INV);
  assign a_ext = {{(IW-W){in_a[W-1]}}, in_a};
  assign b_ext = {{(IW-W-1){in_b[W]}}, in_b};

  haar_half #(.N(IW)) half_in_u   (.x(b_ext), .y(b_half));
  haar_half #(.N(IW)) half_diff_u (.x(diff),  .y(diff_half));

  // subtractor: forward odd - even, inverse s - floor(d/2)
  always_comb begin
    sub_m = inv ? a_ext  : b_ext;
    sub_s = inv ? b_half : a_ext;
  end
  assign diff = sub_m - sub_s;

  // adder: forward even + floor(d/2), inverse d + even
  always_comb begin
    add_x = inv ? b_ext : a_ext;
    add_y = inv ? diff  : diff_half;
  end
  assign sum = add_x + add_y;

  assign res1 = diff[W:0];
  assign res2 = sum[W-1:0];
endmodule

// File: rtl/haar_out_reg.sv
module haar_out_reg #(
  parameter int W1 = 17,
  parameter int W2 = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W1-1:0] d1,
  input  logic [W2-1:0] d2,
  output logic [W1-1:0] q1,
  output logic [W2-1:0] q2,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q1    <= '0;
      q2    <= '0;
      valid <= 1'b0;
    end else begin
      valid <= en;
      if (en) begin
        q1 <= d1;
        q2 <= d2;
      end
    end
  end
endmodule

// File: rtl/haar_lift_unit.sv
module haar_lift_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         mode,
  input  logic [W-1:0] in_a,
  input  logic [W:0]   in_b,
  output logic [W:0]   y1,
  output logic [W-1:0] y2,
  output logic         out_valid
);
  logic [W:0]   res1;
  logic [W-1:0] res2;

  haar_lift_core #(.W(W)) core_u (
    .mode(mode), .in_a(in_a), .in_b(in_b), .res1(res1), .res2(res2)
  );

  haar_out_reg #(.W1(W+1), .W2(W)) oreg_u (
    .clk(clk), .rst(rst), .en(en), .d1(res1), .d2(res2),
    .q1(y1), .q2(y2), .valid(out_valid)
  );
endmodule

// File: rtl/haar_lift_unit_chk.sv
module haar_lift_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         mode,
  input logic [W-1:0] in_a,
  input logic [W:0]   in_b,
  input logic [W:0]   y1,
  input logic [W-1:0] y2,
  input logic         out_valid
);
  // R1
  fwd_detail_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !mode) |=> int'($signed(y1)) ==
      int'($signed($past(in_b))) - int'($signed($past(in_a))));

  // R2
  fwd_smooth_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !mode) |=>
      ((2 * int'($signed(y2)) == int'($signed($past(in_b))) + int'($signed($past(in_a)))) ||
       (2 * int'($signed(y2)) + 1 == int'($signed($past(in_b))) + int'($signed($past(in_a))))));

  // R4
  inv_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode) |=> int'($signed(y2)) ==
      int'($signed($past(in_b))) + int'($signed(y1)));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_valid && $stable(y1) && $stable(y2)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && y1 == '0 && y2 == '0));
endmodule

bind haar_lift_unit haar_lift_unit_chk #(.W(W)) chk_u (
  .clk(clk), .rst(rst), .en(en), .mode(mode), .in_a(in_a), .in_b(in_b),
  .y1(y1), .y2(y2), .out_valid(out_valid)
);

// File: tb/haar_lift_unit_test.sv
`timescale 1ns/1ps
module haar_lift_unit_test;
  localparam int W    = 6;
  localparam int LO   = -(1 << (W-1));
  localparam int HI   = (1 << (W-1)) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W:0]   in_b = '0;
  logic [W:0]   y1;
  logic [W-1:0] y2;
  logic         out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  haar_lift_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .in_a(in_a), .in_b(in_b),
    .y1(y1), .y2(y2), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int floor_half(input int t);
    if (t < 0 && (t % 2) != 0) return (t - 1) / 2;
    return t / 2;
  endfunction

  task automatic drive(input bit e, input bit m, input int a, input int b);
    en   = e;
    mode = m;
    in_a = a[W-1:0];
    in_b = b[W:0];
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d, s, e2, o2;
    @(negedge clk);
    step;
    step;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
    chk(y1 == '0, "R9 y1", int'($signed(y1)), 0);
    chk(y2 == '0, "R9 y2", int'($signed(y2)), 0);
    rst = 1'b0;

    // R2 shifter examples
    drive(1, 0, 0, 13); step;
    chk(int'($signed(y2)) == 6, "R2 +13", int'($signed(y2)), 6);
    drive(1, 0, 0, -13); step;
    chk(int'($signed(y2)) == -7, "R2 -13", int'($signed(y2)), -7);

    // Exhaustive forward/inverse round trip, modes alternating each cycle (R1 R3 R4 R5 R6 R8)
    for (int ev = LO; ev <= HI; ev++) begin
      for (int od = LO; od <= HI; od++) begin
        drive(1, 0, ev, od); step;
        d = int'($signed(y1));
        s = int'($signed(y2));
        chk(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
        chk(d == od - ev, "R1 detail", d, od - ev);
        chk(s == floor_half(ev + od), "R2 smooth", s, floor_half(ev + od));
        drive(1, 1, s, d); step;
        e2 = int'($signed(y1));
        o2 = int'($signed(y2));
        chk(e2 == s - floor_half(d), "R3 even", e2, s - floor_half(d));
        chk(o2 == d + e2, "R4 odd", o2, d + e2);
        chk(e2 == ev && o2 == od, "R5 round trip", e2 * 1000 + o2, ev * 1000 + od);
        chk(out_valid == 1'b1, "R8 mode switch valid", int'(out_valid), 1);
      end
    end

    // R7 enable low holds outputs
    drive(1, 0, 3, -5); step;
    drive(0, 1, 17, 9); step;
    chk(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
    chk(int'($signed(y1)) == -8, "R7 y1 hold", int'($signed(y1)), -8);
    chk(int'($signed(y2)) == -1, "R7 y2 hold", int'($signed(y2)), -1);
    drive(0, 0, -20, 20); step;
    chk(int'($signed(y1)) == -8, "R7 y1 hold2", int'($signed(y1)), -8);

    // R10 eight pairs (16 samples) done within 9 cycles
    begin
      int nv;
      nv = 0;
      for (int k = 0; k < 8; k++) begin
        drive(1, 0, k, 2 * k + 1); step;
        if (out_valid) nv++;
        chk(int'($signed(y1)) == k + 1, "R10 stream detail", int'($signed(y1)), k + 1);
      end
      drive(0, 0, 0, 0); step;
      chk(nv == 8, "R10 results by cycle 9", nv, 8);
      chk(out_valid == 1'b0, "R10 idle after", int'(out_valid), 0);
    end

    // R9 mid-run reset
    drive(1, 0, HI, LO); rst = 1'b1; step;
    chk(out_valid == 1'b0 && y1 == '0 && y2 == '0, "R9 midrun", int'(out_valid), 0);
    rst = 1'b0;
    drive(0, 0, 0, 0); step;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule